// File: doc/BRIEF.md
# Disk Controller Host Command, Status and Interrupt Front End

This block is the part of a sector-buffered disk controller that the host processor talks to. It holds the command byte most recently written by the host. It keeps the status bits for busy, error, corrected, data request and bad block. It raises a controller interrupt whenever the host has to act, and it drives a hardware data-request line toward a DMA controller. An abstract internal sequencer tells the block when an operation finishes, when faults occur, when a byte is ready and when the buffer has been emptied.

Two command bits shape the completion. Bit 4 separates a sector read (0) from every other command (1). Bit 0 selects DMA operation for a read. A programmed-I/O read completes, and interrupts, as soon as the sector is in the buffer. A DMA read completes only after the buffer has been drained. A routing stage passes either the controller interrupt or an external DMA terminal-count interrupt to the system, depending on bit 4 of the current command. An access to the cylinder-low register drops the hardware data-request line without touching the status bit.

Top module: `dkc_host_front`

## Requirements
- R1: After reset the status byte reads 0x00, and ctl_irq, drq_line and sys_irq are all 0.
- R2: A write to address 7 latches the command and, one cycle later, sets Busy (status bit 7) and clears Error (bit 0), Bad Block (bit 1) and Corrected (bit 2).
- R3: While Busy, for a command with bit 4 = 1, or with bit 4 = 0 and bit 0 = 0, a seq_done pulse clears Busy and raises ctl_irq one cycle later.
- R4: While Busy, for a command with bit 4 = 0 and bit 0 = 1, seq_done leaves Busy set and ctl_irq low. A later buf_drained pulse clears Busy and raises ctl_irq one cycle later.
- R5: A seq_err pulse while Busy sets Error (bit 0). Completion then behaves exactly as without an error: Busy clears and ctl_irq rises.
- R6: A seq_corr pulse while Busy sets Corrected (bit 2). Busy stays set and ctl_irq stays low.
- R7: A seq_bad pulse while Busy sets both Bad Block (bit 1) and Error (bit 0).
- R8: A host read of address 7 returns the status byte on host_rdata one cycle later and clears ctl_irq in that same cycle, unless a completion occurs in the cycle of the read.
- R9: A seq_byte_rdy pulse sets drq_line and the DRQ status bit (bit 3) one cycle later. A host read or write of the data address 0 clears both.
- R10: A host read or write of the cylinder-low address 4 clears drq_line one cycle later and leaves the DRQ status bit unchanged.
- R11: sys_irq equals ctl_irq, delayed one cycle, when command bit 4 = 1. It equals dma_tc_irq, registered one cycle, when command bit 4 = 0.
- R12: A command write in the same cycle as seq_done takes priority: Busy ends up set and ctl_irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data (status at address 7, otherwise 0) |
| seq_done | input | 1 | Sequencer: operation finished or sector in buffer |
| seq_err | input | 1 | Sequencer: fatal error |
| seq_corr | input | 1 | Sequencer: corrected error |
| seq_bad | input | 1 | Sequencer: bad block hit |
| seq_byte_rdy | input | 1 | Sequencer: a byte is ready to move |
| buf_drained | input | 1 | Sequencer: sector buffer fully transferred out |
| dma_tc_irq | input | 1 | External DMA controller terminal-count interrupt |
| ctl_irq | output | 1 | Controller interrupt request |
| drq_line | output | 1 | Hardware data-request line |
| sys_irq | output | 1 | Routed system interrupt |

## Verification
Every result of this block appears exactly one clock after the input that causes it: status bits, ctl_irq, drq_line, host_rdata and the registered dma_tc_irq path to sys_irq. The controller-interrupt path to sys_irq is the exception: it appears two clocks after its cause. The bench drives inputs on the falling edge and samples on the next falling edge, which lands after the single register stage. For the sys_irq path that follows ctl_irq, it waits one more falling edge. Status reads go through a scoreboard queue: the read task queues the expected byte, and a monitor compares host_rdata on the falling edge that follows the clock edge which captured the read.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  // status byte bit positions
  localparam int ST_ERR_BIT  = 0;
  localparam int ST_BAD_BIT  = 1;
  localparam int ST_CORR_BIT = 2;
  localparam int ST_DRQ_BIT  = 3;
  localparam int ST_BUSY_BIT = 7;
  // command byte bit positions
  localparam int CMD_DMA_BIT     = 0;
  localparam int CMD_NONREAD_BIT = 4;

  typedef struct packed {
    logic busy;
    logic err;
    logic corr;
    logic bad;
  } dkc_state_t;

  function automatic logic [7:0] dkc_status_byte(dkc_state_t s, logic drq);
    logic [7:0] b;
    b = '0;
    b[ST_BUSY_BIT] = s.busy;
    b[ST_ERR_BIT]  = s.err;
    b[ST_CORR_BIT] = s.corr;
    b[ST_BAD_BIT]  = s.bad;
    b[ST_DRQ_BIT]  = drq;
    return b;
  endfunction
endpackage

// File: rtl/dkc_cmd_status.sv
module dkc_cmd_status
  import dkc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              stat_rd,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic              seq_corr,
  input  logic              seq_bad,
  input  logic              buf_drained,
  output logic [DATA_W-1:0] cmd_q,
  output dkc_state_t        st_q,
  output logic              ctl_irq
);
  logic wait_drain_q;
  logic is_read, is_dma_read, finish, arm_drain;

  assign is_read     = ~cmd_q[CMD_NONREAD_BIT];
  assign is_dma_read = is_read & cmd_q[CMD_DMA_BIT];
  assign finish      = st_q.busy &
                       ((seq_done & ~is_dma_read & ~wait_drain_q) |
                        (wait_drain_q & buf_drained));
  assign arm_drain   = st_q.busy & seq_done & is_dma_read & ~wait_drain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q        <= '0;
      st_q         <= '0;
      wait_drain_q <= 1'b0;
      ctl_irq      <= 1'b0;
    end else if (cmd_wr) begin
      cmd_q        <= cmd_byte;
      st_q.busy    <= 1'b1;
      st_q.err     <= 1'b0;
      st_q.corr    <= 1'b0;
      st_q.bad     <= 1'b0;
      wait_drain_q <= 1'b0;
      ctl_irq      <= 1'b0;
    end else begin
      if (st_q.busy && seq_err)  st_q.err  <= 1'b1;
      if (st_q.busy && seq_corr) st_q.corr <= 1'b1;
      if (st_q.busy && seq_bad) begin
        st_q.bad <= 1'b1;
        st_q.err <= 1'b1;
      end
      if (arm_drain) wait_drain_q <= 1'b1;
      if (finish) begin
        st_q.busy    <= 1'b0;
        wait_drain_q <= 1'b0;
        ctl_irq      <= 1'b1;
      end else if (stat_rd) begin
        ctl_irq <= 1'b0;
      end
    end
  end

  // R2
  cmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> st_q.busy && !st_q.err && !st_q.corr && !st_q.bad && !ctl_irq);
  // R3
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr && st_q.busy && seq_done && !is_dma_read && !wait_drain_q)
      |=> ctl_irq && !st_q.busy);
  // R4
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr && arm_drain) |=> st_q.busy && !ctl_irq);
  // R6
  corr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_wr && st_q.busy && seq_corr && !seq_done && !buf_drained)
      |=> st_q.corr && st_q.busy);
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !cmd_wr && !finish) |=> !ctl_irq);
endmodule

// File: rtl/dkc_drq.sv
module dkc_drq (
  input  logic clk,
  input  logic rst,
  input  logic byte_rdy,
  input  logic data_acc,
  input  logic cyl_acc,
  output logic drq_line,
  output logic drq_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drq_line <= 1'b0;
      drq_bit  <= 1'b0;
    end else begin
      if (byte_rdy)                 drq_line <= 1'b1;
      else if (data_acc || cyl_acc) drq_line <= 1'b0;
      if (byte_rdy)                 drq_bit  <= 1'b1;
      else if (data_acc)            drq_bit  <= 1'b0;
    end
  end

  // R9
  drq_set_chk: assert property (@(posedge clk) disable iff (rst)
    byte_rdy |=> drq_line && drq_bit);
  // R10
  cyl_line_chk: assert property (@(posedge clk) disable iff (rst)
    (cyl_acc && !byte_rdy) |=> !drq_line);
  // R10
  cyl_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cyl_acc && !byte_rdy && !data_acc) |=> $stable(drq_bit));
endmodule

// File: rtl/dkc_irq_route.sv
module dkc_irq_route (
  input  logic clk,
  input  logic rst,
  input  logic use_ctl,
  input  logic ctl_irq,
  input  logic ext_irq,
  output logic sys_irq
);
  always_ff @(posedge clk) begin
    if (rst) sys_irq <= 1'b0;
    else     sys_irq <= use_ctl ? ctl_irq : ext_irq;
  end

  // R11
  route_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!use_ctl && !ext_irq) |=> !sys_irq);
endmodule

// File: rtl/dkc_host_front.sv
module dkc_host_front
  import dkc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int DATA_ADDR   = 0,
  parameter int CYL_LO_ADDR = 4,
  parameter int CMD_ADDR    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic              seq_corr,
  input  logic              seq_bad,
  input  logic              seq_byte_rdy,
  input  logic              buf_drained,
  input  logic              dma_tc_irq,
  output logic              ctl_irq,
  output logic              drq_line,
  output logic              sys_irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_CYL  = ADDR_W'(CYL_LO_ADDR);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_ADDR);

  logic              acc, cmd_wr, stat_rd, data_acc, cyl_acc, drq_bit;
  logic [DATA_W-1:0] cmd_q;
  dkc_state_t        st_q;
  logic [7:0]        status_b;

  assign acc      = host_rd | host_wr;
  assign cmd_wr   = host_wr & (host_addr == A_CMD);
  assign stat_rd  = host_rd & (host_addr == A_CMD);
  assign data_acc = acc & (host_addr == A_DATA);
  assign cyl_acc  = acc & (host_addr == A_CYL);

  dkc_cmd_status #(.DATA_W(DATA_W)) u_cmd_status (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(host_wdata),
    .stat_rd(stat_rd), .seq_done(seq_done), .seq_err(seq_err),
    .seq_corr(seq_corr), .seq_bad(seq_bad), .buf_drained(buf_drained),
    .cmd_q(cmd_q), .st_q(st_q), .ctl_irq(ctl_irq)
  );

  dkc_drq u_drq (
    .clk(clk), .rst(rst), .byte_rdy(seq_byte_rdy), .data_acc(data_acc),
    .cyl_acc(cyl_acc), .drq_line(drq_line), .drq_bit(drq_bit)
  );

  dkc_irq_route u_route (
    .clk(clk), .rst(rst), .use_ctl(cmd_q[CMD_NONREAD_BIT]),
    .ctl_irq(ctl_irq), .ext_irq(dma_tc_irq), .sys_irq(sys_irq)
  );

  assign status_b = dkc_status_byte(st_q, drq_bit);

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (stat_rd) host_rdata <= DATA_W'(status_b);
    else if (host_rd) host_rdata <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !ctl_irq && !drq_line && !sys_irq && host_rdata == '0);
  // R12
  cmd_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && seq_done) |=> st_q.busy && !ctl_irq);
endmodule

// File: tb/test_dkc_host_front.sv
module test_dkc_host_front;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic host_rd = 0, host_wr = 0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic seq_done = 0, seq_err = 0, seq_corr = 0, seq_bad = 0;
  logic seq_byte_rdy = 0, buf_drained = 0, dma_tc_irq = 0;
  logic ctl_irq, drq_line, sys_irq;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_fire = 1'b0;

  dkc_host_front i_dkc_host_front (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .seq_done(seq_done), .seq_err(seq_err), .seq_corr(seq_corr),
    .seq_bad(seq_bad), .seq_byte_rdy(seq_byte_rdy), .buf_drained(buf_drained),
    .dma_tc_irq(dma_tc_irq), .ctl_irq(ctl_irq), .drq_line(drq_line),
    .sys_irq(sys_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_acc(input logic rd, input logic wr, input logic [2:0] a,
                          input logic [7:0] d);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_rd = 0; host_wr = 0;
  endtask

  task automatic rd_status(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_acc(1'b1, 1'b0, 3'd7, 8'h00);
  endtask

  // 0 done, 1 err, 2 corr, 3 bad, 4 byte, 5 drained, 6 dma tc
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: seq_done = 1;
      1: seq_err = 1;
      2: seq_corr = 1;
      3: seq_bad = 1;
      4: seq_byte_rdy = 1;
      5: buf_drained = 1;
      default: dma_tc_irq = 1;
    endcase
    @(negedge clk);
    seq_done = 0; seq_err = 0; seq_corr = 0; seq_bad = 0;
    seq_byte_rdy = 0; buf_drained = 0; dma_tc_irq = 0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_fire <= host_rd && (host_addr == 3'd7);
  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, host_rdata, e);
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ctl_irq", {7'd0, ctl_irq}, 8'd0);
    chk("R1 drq_line", {7'd0, drq_line}, 8'd0);
    chk("R1 sys_irq", {7'd0, sys_irq}, 8'd0);
    rd_status(8'h00, "R1 status");

    // non-read command
    host_acc(0, 1, 3'd7, 8'h30);
    rd_status(8'h80, "R2 busy");
    pulse(2);
    chk("R6 no irq", {7'd0, ctl_irq}, 8'd0);
    rd_status(8'h84, "R6 corrected");
    pulse(1);
    rd_status(8'h85, "R5 error");
    pulse(0);
    chk("R3 R5 irq", {7'd0, ctl_irq}, 8'd1);
    @(negedge clk);
    chk("R11 ctl route", {7'd0, sys_irq}, 8'd1);
    rd_status(8'h05, "R3 busy clear");
    chk("R8 irq cleared", {7'd0, ctl_irq}, 8'd0);

    // programmed-I/O read
    host_acc(0, 1, 3'd7, 8'h20);
    rd_status(8'h80, "R2 clears flags");
    pulse(6);
    chk("R11 ext route", {7'd0, sys_irq}, 8'd1);
    pulse(0);
    chk("R3 pio irq", {7'd0, ctl_irq}, 8'd1);
    @(negedge clk);
    chk("R11 ctl masked", {7'd0, sys_irq}, 8'd0);
    rd_status(8'h00, "R3 pio done");

    // DMA read
    host_acc(0, 1, 3'd7, 8'h21);
    pulse(0);
    chk("R4 no irq on done", {7'd0, ctl_irq}, 8'd0);
    rd_status(8'h80, "R4 still busy");
    pulse(4);
    chk("R9 drq line", {7'd0, drq_line}, 8'd1);
    rd_status(8'h88, "R9 drq bit");
    host_acc(0, 1, 3'd4, 8'h00);
    chk("R10 line cleared", {7'd0, drq_line}, 8'd0);
    rd_status(8'h88, "R10 bit kept");
    host_acc(1, 0, 3'd0, 8'h00);
    rd_status(8'h80, "R9 data clears bit");
    pulse(5);
    chk("R4 irq on drain", {7'd0, ctl_irq}, 8'd1);
    rd_status(8'h00, "R4 busy clear");

    // bad block, then command colliding with done
    host_acc(0, 1, 3'd7, 8'h30);
    pulse(3);
    rd_status(8'h83, "R7 bad block");
    @(negedge clk);
    host_wr = 1; host_addr = 3'd7; host_wdata = 8'h30; seq_done = 1;
    @(negedge clk);
    host_wr = 0; seq_done = 0;
    chk("R12 no irq", {7'd0, ctl_irq}, 8'd0);
    rd_status(8'h80, "R12 busy kept");

    @(negedge clk);
    finish_run();
  end
endmodule